// File: doc/BRIEF.md
# Two-Byte Buffered SPI Bus Bridge

This block sits between a host microcontroller's SPI master port and the byte-level framer of a slow two-wire message bus. It holds a 16-bit buffer that both sides take turns to own. A single open-drain handshake line, CONTROL, shows who owns the buffer. The block releases CONTROL (high) while the host owns the buffer. It pulls CONTROL low while the bus side owns it. Every host access is one 16-bit exchange. The bits the host shifts in replace the bits that are shifted back out, so the host always reads what the bus last left behind.

When the host wants to transmit, it completes an exchange and then pulls CONTROL low. The block latches that request by driving CONTROL low itself. It then offers the two buffered bytes to the framer one at a time. It writes each byte that the framer reads back from the bus over the byte just sent. Reception works the same way. Once the host has completed an exchange, the first received data bit takes the buffer. The received bytes are stored, and CONTROL is released after two bytes, or after one byte if the bus then goes idle. Framing errors, the end-of-message strobe and host chip select modify this sequence as set out below. SCK, chip select, MOSI and the CONTROL line are resynchronised into the system clock, which must run at least four times faster than SCK.

Top module: `dbuf_spi_bridge`

## Requirements
- R1: The SPI output enable `miso_oe` is high only while `mode_sel` is 0 and `cs_n` is 0. With either input high it is low, and `ctl_drive_low` and the bus handshakes keep working.
- R2: The SPI format uses clock idle low. Data changes on the rising edge and is captured on the falling edge. A 16-bit exchange sends buffer byte 0 first and each byte most significant bit first. Bit k of the exchange returns the buffer bit held at that position before the exchange and replaces it with the MOSI bit.
- R3: After reset, `ctl_drive_low` and `tx_valid` are 0 and the buffer reads as all zeros. Neither `rx_start` nor a host low on CONTROL takes the buffer until the host has completed one full 16-bit exchange.
- R4: If chip select goes high before 16 bits, the exchange restarts at bit 0 on the next selection. The bits already shifted are kept, but the exchange does not count as complete.
- R5: With the exchange complete, a low on the CONTROL line makes the block drive CONTROL low. It keeps CONTROL low until two reflected bytes have returned. It offers byte 0 and then byte 1 on `tx_byte`, and holds each with `tx_valid` until `tx_ack`.
- R6: Each reflected byte (`rx_valid` after `tx_ack`) overwrites the byte it answers. After the second one, CONTROL is released and a new host exchange is needed before the bus may take the buffer again.
- R7: With the exchange complete, `rx_start` makes the block drive CONTROL low. The next two `rx_valid` bytes are stored as byte 0 and byte 1, and CONTROL is then released.
- R8: If `bus_idle` is high after exactly one received byte, CONTROL is released and that byte is held in byte 0.
- R9: A byte flagged by `rx_ferr` as the first byte of a reception is not stored. CONTROL stays low until `eom`, and after that the bus side may take the buffer again without a new host exchange.
- R10: A byte flagged by `rx_ferr` as the second byte is stored and CONTROL is released. Until `eom`, no `rx_valid` byte is stored and `rx_start` does not take the buffer.
- R11: A bus byte that arrives while the host owns the buffer, before its exchange completes, overwrites byte 0 (and the next one byte 1), and the host data in that byte is lost.
- R12: The block samples the CONTROL line only while it has released it. Its own low drive never starts a transmission after a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Mode strap; 0 selects this buffered mode |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI clock from the host |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| miso_oe | output | 1 | Output enable for miso (tri-state when low) |
| ctl_in | input | 1 | Sampled level of the CONTROL line |
| ctl_drive_low | output | 1 | Pull CONTROL low when 1, release when 0 |
| bus_idle | input | 1 | Bus is idle |
| eom | input | 1 | End-of-message strobe |
| rx_start | input | 1 | Strobe at the first received data bit |
| rx_valid | input | 1 | Strobe: received or reflected byte ready |
| rx_byte | input | BYTE_W | Received or reflected byte |
| rx_ferr | input | 1 | Framing error on the byte given with rx_valid |
| tx_valid | output | 1 | A byte waits for the framer |
| tx_byte | output | BYTE_W | Byte to transmit |
| tx_ack | input | 1 | Framer accepted tx_byte |

## Verification
On every cycle the assertions check that reset leaves CONTROL released and nothing offered, and that a transmit byte is only offered while CONTROL is held low. They also check that the offered byte stays stable until it is acknowledged, that it drops after the acknowledge, and that CONTROL is never released except on a returned byte, bus idle or end-of-message. The bench's scenarios are needed for the data itself: swap contents, reflected-byte overwrite, the single-byte release, and the two framing-error paths. The same goes for the host-collision overwrite and for gating the bus side until an exchange completes, since each depends on a whole sequence of SPI bits and bus events.

// File: rtl/dbsb_pkg.sv
package dbsb_pkg;
   typedef enum logic [1:0] {
      OWN_HOST = 2'd0,
      OWN_TX   = 2'd1,
      OWN_RX   = 2'd2,
      OWN_HOLD = 2'd3
   } own_st_t;
endpackage

// File: rtl/dbsb_sync.sv
module dbsb_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbsb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dbsb_spi_slave.sv
module dbsb_spi_slave #(
   parameter int TOTAL_BITS = 16,
   localparam int IW = $clog2(TOTAL_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          sck_s,
   output logic          rise,
   output logic          fall,
   output logic [IW-1:0] idx,
   output logic          done
);
   localparam logic [IW-1:0] LAST = IW'(TOTAL_BITS - 1);

   logic sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   assign rise = sel & sck_s & ~sck_q;
   assign fall = sel & ~sck_s & sck_q;
   assign done = fall & (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (!sel)   idx <= '0;
      else if (fall)   idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/dbsb_own_fsm.sv
module dbsb_own_fsm
   import dbsb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_done,
   input  logic ctl_s,
   input  logic rx_start,
   input  logic rx_valid,
   input  logic rx_ferr,
   input  logic bus_idle,
   input  logic eom,
   input  logic tx_ack,
   output logic ctl_low,
   output logic tx_valid,
   output logic slot,
   output logic wr_en,
   output logic host_own
);
   localparam int MASK_LEN = SYNC_STAGES + 1;
   localparam int MW = $clog2(MASK_LEN + 1);
   localparam logic [MW-1:0] MASK_VAL = MW'(MASK_LEN);

   own_st_t       st;
   logic          full;
   logic          idx;
   logic          sent;
   logic          nold;
   logic [MW-1:0] mask;
   logic          ctl_req;

   assign ctl_req  = ~ctl_s && (mask == '0);
   assign ctl_low  = (st != OWN_HOST);
   assign tx_valid = (st == OWN_TX) && !sent;
   assign host_own = (st == OWN_HOST);
   assign slot     = idx;

   always_comb begin
      wr_en = 1'b0;
      unique case (st)
         OWN_HOST: wr_en = rx_valid && !nold;
         OWN_TX:   wr_en = rx_valid && sent;
         OWN_RX:   wr_en = rx_valid && !(rx_ferr && !idx);
         default:  wr_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= OWN_HOST;
         full <= 1'b0;
         idx  <= 1'b0;
         sent <= 1'b0;
         nold <= 1'b0;
         mask <= '0;
      end else begin
         if (mask != '0) mask <= mask - 1'b1;
         unique case (st)
            OWN_HOST: begin
               if (spi_done) full <= 1'b1;
               if (eom)      nold <= 1'b0;
               if (full && rx_start && !nold) begin
                  st  <= OWN_RX;
                  idx <= 1'b0;
               end else if (full && ctl_req) begin
                  st   <= OWN_TX;
                  idx  <= 1'b0;
                  sent <= 1'b0;
               end else if (rx_valid && !nold) begin
                  idx <= ~idx;
               end
            end
            OWN_TX: begin
               if (!sent && tx_ack) begin
                  sent <= 1'b1;
               end else if (sent && rx_valid) begin
                  sent <= 1'b0;
                  if (idx) begin
                     st   <= OWN_HOST;
                     full <= 1'b0;
                     idx  <= 1'b0;
                     mask <= MASK_VAL;
                  end else begin
                     idx <= 1'b1;
                  end
               end
            end
            OWN_RX: begin
               if (rx_valid) begin
                  if (rx_ferr && !idx) begin
                     st <= OWN_HOLD;
                  end else if (rx_ferr || idx) begin
                     st   <= OWN_HOST;
                     full <= 1'b0;
                     idx  <= 1'b0;
                     mask <= MASK_VAL;
                     if (rx_ferr) nold <= 1'b1;
                  end else begin
                     idx <= 1'b1;
                  end
               end else if (bus_idle) begin
                  st   <= OWN_HOST;
                  if (idx) full <= 1'b0;
                  idx  <= 1'b0;
                  mask <= MASK_VAL;
               end
            end
            OWN_HOLD: begin
               if (eom) begin
                  st   <= OWN_HOST;
                  idx  <= 1'b0;
                  mask <= MASK_VAL;
               end
            end
            default: st <= OWN_HOST;
         endcase
      end
   end
endmodule

// File: rtl/dbuf_spi_bridge.sv
module dbuf_spi_bridge #(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_sel,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic              miso_oe,
   input  logic              ctl_in,
   output logic              ctl_drive_low,
   input  logic              bus_idle,
   input  logic              eom,
   input  logic              rx_start,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_ferr,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_ack
);
   localparam int BUF_BYTES = 2;
   localparam int TOTAL     = BYTE_W * BUF_BYTES;
   localparam int IW        = $clog2(TOTAL);
   localparam logic [IW-1:0] LASTB = IW'(TOTAL - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("dbuf_spi_bridge: BYTE_W must be at least 2");
   end

   logic mode_s, cs_s, sck_s, mosi_s, ctl_s;
   logic sel_s;
   logic rise, fall, spi_done;
   logic [IW-1:0] bit_idx;
   logic slot, wr_en, host_own;
   logic [TOTAL-1:0] buf_q;
   logic miso_q;

   dbsb_sync #(
      .WIDTH  (5),
      .STAGES (SYNC_STAGES),
      .RST_VAL(5'b11001)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({mode_sel, cs_n, sck, mosi, ctl_in}),
      .q    ({mode_s, cs_s, sck_s, mosi_s, ctl_s})
   );

   assign sel_s = ~mode_s & ~cs_s;

   dbsb_spi_slave #(.TOTAL_BITS(TOTAL)) u_spi (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (sel_s),
      .sck_s(sck_s),
      .rise (rise),
      .fall (fall),
      .idx  (bit_idx),
      .done (spi_done)
   );

   dbsb_own_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .spi_done(spi_done && host_own),
      .ctl_s   (ctl_s),
      .rx_start(rx_start),
      .rx_valid(rx_valid),
      .rx_ferr (rx_ferr),
      .bus_idle(bus_idle),
      .eom     (eom),
      .tx_ack  (tx_ack),
      .ctl_low (ctl_drive_low),
      .tx_valid(tx_valid),
      .slot    (slot),
      .wr_en   (wr_en),
      .host_own(host_own)
   );

   // Byte 0 occupies the upper half; SPI bit k maps to buf_q[TOTAL-1-k].
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else begin
         if (fall && host_own) buf_q[LASTB - bit_idx] <= mosi_s;
         if (wr_en) begin
            if (slot) buf_q[BYTE_W-1:0]      <= rx_byte;
            else      buf_q[TOTAL-1 -: BYTE_W] <= rx_byte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    miso_q <= 1'b0;
      else if (rise) miso_q <= buf_q[LASTB - bit_idx];
   end

   assign miso    = miso_q;
   assign miso_oe = ~mode_sel & ~cs_n;
   assign tx_byte = slot ? buf_q[BYTE_W-1:0] : buf_q[TOTAL-1 -: BYTE_W];
endmodule

// File: rtl/dbsb_checker.sv
module dbsb_checker #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_drive_low,
   input logic              tx_valid,
   input logic [BYTE_W-1:0] tx_byte,
   input logic              tx_ack,
   input logic              rx_valid,
   input logic              bus_idle,
   input logic              eom
);
   AST_RESET_RELEASED: assert property (@(posedge clk)
      !rst_n |=> (!ctl_drive_low && !tx_valid)); // R3

   AST_TX_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ctl_drive_low); // R5

   AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_byte))); // R5

   AST_TX_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ack) |=> !tx_valid); // R5

   AST_CTL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_drive_low && !rx_valid && !bus_idle && !eom) |=> ctl_drive_low); // R6
endmodule

bind dbuf_spi_bridge dbsb_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_drive_low(ctl_drive_low),
   .tx_valid     (tx_valid),
   .tx_byte      (tx_byte),
   .tx_ack       (tx_ack),
   .rx_valid     (rx_valid),
   .bus_idle     (bus_idle),
   .eom          (eom)
);

// File: tb/dbuf_spi_bridge_test.sv
module dbuf_spi_bridge_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, mode_sel, cs_n, sck, mosi, miso, miso_oe;
   logic       ctl_drive_low, bus_idle, eom, rx_start, rx_valid, rx_ferr;
   logic [7:0] rx_byte, tx_byte;
   logic       tx_valid, tx_ack;
   logic       host_pull;
   logic       ctl_in;
   assign ctl_in = ~(ctl_drive_low | host_pull);

   dbuf_spi_bridge uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .sck(sck),
      .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .ctl_in(ctl_in),
      .ctl_drive_low(ctl_drive_low), .bus_idle(bus_idle), .eom(eom),
      .rx_start(rx_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_ferr(rx_ferr), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ack(tx_ack)
   );

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   logic [15:0] mbuf;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errs++;
         $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // SPI master: clock idle low, change on rise, capture on fall, 80 ns period.
   task automatic spi_xfer(input logic [15:0] tx, input int nbits, input bit inj,
                           input logic [7:0] injb, output logic [15:0] rx);
      rx = '0;
      cs_n = 1'b0;
      #40;
      for (int k = 0; k < nbits; k++) begin
         sck = 1'b1;
         mosi = tx[15-k];
         #40;
         rx[15-k] = miso;
         sck = 1'b0;
         #40;
         if (inj && k == 7) begin
            repeat (4) @(negedge clk);
            rx_byte = injb;
            rx_valid = 1'b1;
            @(negedge clk);
            rx_valid = 1'b0;
         end
      end
      #40;
      cs_n = 1'b1;
      #40;
   endtask

   task automatic swap(input logic [15:0] nv, input string req, input bit mask_lo);
      logic [15:0] r;
      spi_xfer(nv, 16, 1'b0, 8'h00, r);
      if (mask_lo) chk(req, r[15:8], mbuf[15:8]);
      else         chk(req, r, mbuf);
      mbuf = nv;
   endtask

   task automatic rxb(input logic [7:0] b, input bit fe);
      rx_byte = b;
      rx_ferr = fe;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_ferr = 1'b0;
      tick(3);
   endtask

   task automatic pulse_start;
      bus_idle = 1'b0;
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      tick(3);
   endtask

   task automatic pulse_eom;
      bus_idle = 1'b1;
      eom = 1'b1;
      @(negedge clk);
      eom = 1'b0;
      tick(3);
   endtask

   task automatic do_tx;
      logic [7:0] refl;
      logic [7:0] e;
      host_pull = 1'b1;
      for (int i = 0; i < 30 && !ctl_drive_low; i++) @(negedge clk);
      chk("R5 ctl latched low on host request", ctl_drive_low, 1);
      host_pull = 1'b0;
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 30 && !tx_valid; i++) @(negedge clk);
         e = (b == 0) ? mbuf[15:8] : mbuf[7:0];
         chk("R5 tx byte order", {tx_valid, tx_byte}, {1'b1, e});
         tick($urandom % 4);
         tx_ack = 1'b1;
         @(negedge clk);
         tx_ack = 1'b0;
         tick(2);
         chk("R5 low held while awaiting reflection", {tx_valid, ctl_drive_low}, 2'b01);
         refl = e & 8'($urandom);
         rxb(refl, 1'b0);
         if (b == 0) mbuf[15:8] = refl;
         else        mbuf[7:0]  = refl;
      end
      chk("R6 released after two reflections", ctl_drive_low, 0);
      swap(16'($urandom), "R6 reflected bytes returned", 1'b0);
   endtask

   task automatic do_rx2;
      logic [7:0] a, b;
      a = 8'($urandom);
      b = 8'($urandom);
      pulse_start();
      chk("R7 ctl low on first received bit", ctl_drive_low, 1);
      rxb(a, 1'b0);
      tick($urandom % 5);
      chk("R7 held low after one byte", ctl_drive_low, 1);
      rxb(b, 1'b0);
      chk("R7 released after two bytes", ctl_drive_low, 0);
      bus_idle = 1'b1;
      mbuf = {a, b};
   endtask

   initial begin
      logic [15:0] r;
      logic [15:0] nv;
      logic [7:0]  x;
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; mode_sel = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
      bus_idle = 1'b1; eom = 1'b0; rx_start = 1'b0; rx_valid = 1'b0;
      rx_byte = '0; rx_ferr = 1'b0; tx_ack = 1'b0; host_pull = 1'b0;
      mbuf = '0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      chk("R3 reset state", {ctl_drive_low, tx_valid}, 2'b00);
      chk("R1 deselected output hiz", miso_oe, 0);
      mode_sel = 1'b1; cs_n = 1'b0; #1;
      chk("R1 other mode output hiz", miso_oe, 0);
      mode_sel = 1'b0; #1;
      chk("R1 selected output on", miso_oe, 1);
      cs_n = 1'b1;
      tick(2);

      // R3: bus side cannot take the buffer before a full exchange
      pulse_start();
      tick(4);
      chk("R3 rx_start ignored before exchange", ctl_drive_low, 0);
      bus_idle = 1'b1;
      host_pull = 1'b1;
      tick(10);
      chk("R3 host request ignored before exchange", {ctl_drive_low, tx_valid}, 2'b00);
      host_pull = 1'b0;
      tick(5);

      // R4: partial exchange
      nv = 16'hA5C3;
      spi_xfer(nv, 8, 1'b0, 8'h00, r);
      chk("R4 partial exchange returns old byte0", r[15:8], mbuf[15:8]);
      mbuf[15:8] = nv[15:8];
      pulse_start();
      tick(4);
      chk("R4 partial exchange not complete", ctl_drive_low, 0);
      bus_idle = 1'b1;

      swap(16'h3C96, "R2 first full exchange", 1'b0);
      swap(16'h0FF0, "R2 swap returns previous contents", 1'b0);

      for (int it = 0; it < 24; it++) begin
         int op;
         op = int'($urandom % 3);
         if (op == 0) begin
            do_tx();
         end else if (op == 1) begin
            do_rx2();
            swap(16'($urandom), "R7 received bytes returned", 1'b0);
         end else begin
            x = 8'($urandom);
            pulse_start();
            rxb(x, 1'b0);
            bus_idle = 1'b1;
            tick(3);
            chk("R8 released after one byte and idle", ctl_drive_low, 0);
            mbuf[15:8] = x;
            swap(16'($urandom), "R8 single byte returned", 1'b1);
         end
      end

      // R11: bus byte during unfinished host exchange
      do_rx2();
      x = 8'h5A;
      nv = 16'h1234;
      spi_xfer(nv, 16, 1'b1, x, r);
      chk("R11 reads before overwrite", r, mbuf);
      mbuf = {x, nv[7:0]};
      swap(16'hBEEF, "R11 bus byte replaced host byte0", 1'b0);

      // R9: framing error on first byte
      pulse_start();
      rxb(8'h77, 1'b1);
      tick(10);
      chk("R9 held low until eom", {ctl_drive_low, tx_valid}, 2'b10);
      pulse_eom();
      tick(2);
      chk("R9 released at eom", ctl_drive_low, 0);
      tick(10);
      chk("R12 no spurious transmit after release", {ctl_drive_low, tx_valid}, 2'b00);
      do_tx();

      // R10: framing error on second byte
      pulse_start();
      rxb(8'h11, 1'b0);
      rxb(8'h22, 1'b1);
      chk("R10 released after error on byte1", ctl_drive_low, 0);
      mbuf = 16'h1122;
      rxb(8'hEE, 1'b0);
      bus_idle = 1'b1;
      swap(16'h4455, "R10 no load until eom", 1'b0);
      pulse_start();
      tick(4);
      chk("R10 rx_start ignored until eom", ctl_drive_low, 0);
      pulse_eom();
      do_rx2();
      swap(16'h6677, "R10 loading resumes after eom", 1'b0);

      tick(10);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule